// File: doc/BRIEF.md
# Reinforcement-Learning Weight Update Engine

This block performs one learning step on the neural routing model kept for a single traffic class. A router holds one such model for each class of traffic. The model has one neuron per router port. Each neuron row carries an excitatory and an inhibitory weight toward every port, and the model also keeps one running threshold. When an acknowledgement returns a reward (the reciprocal of the packet's quality goal), the caller pulses `start`. With that pulse it presents the reward, the port chosen earlier for that flow, the stored threshold and the row's current weights.

The engine first folds the reward into the threshold as an exponential running average. It then compares the reward with the old threshold. If the reward is at least the old threshold, the route is reinforced; otherwise it is penalised. The difference goes in full to one weight of the chosen port, and one share of it, divided by n−1, goes to each of the other ports, on the opposite weight set. Finally the whole row is rescaled so that its total firing rate matches the total it had before the step. Division by n−1 and the rescale ratio both run on one shared multicycle restoring divider. `done` pulses once the last weight has been written back, and the updated row is then held on the parallel outputs for the caller to store.

All quantities are unsigned fixed point (Q8.8 by default). The averaging coefficient is 1 − 2^−AVG_SHIFT.

Top module: `rlw_update_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `thr_out`, `wex_out` and `win_out` are all zero.
- R2: The threshold presented at `done` equals T − (T >> AVG_SHIFT) + (R >> AVG_SHIFT), computed on raw codes with truncating shifts, where T is `thr_in` and R is `reward`.
- R3: When R ≥ T (equality included), the chosen port's excitatory weight gains d = R − T. Every other port's inhibitory weight gains floor(d / (N_PORTS−1)). All remaining weights are unchanged before rescaling.
- R4: When R < T, every non-chosen port's excitatory weight gains floor(d / (N_PORTS−1)) with d = T − R, and the chosen port's inhibitory weight gains d. All remaining weights are unchanged before rescaling.
- R5: Any adjusted weight whose sum exceeds 0xFFFF is clamped to 0xFFFF.
- R6: Let r_old be the sum of the 2·N_PORTS weights at `start` and r_new the sum after adjustment and clamping. Each final weight is floor(w_adj · r_old / r_new). When r_new is zero, the weights stay as adjusted.
- R7: `busy` is 1 from the cycle after an accepted `start` until the `done` cycle inclusive. `done` is a single-cycle pulse, and all outputs hold their values while the engine is idle and `start` is low.
- R8: A `start` pulse that arrives while `busy` is 1 is ignored: the update in progress completes with its original operands.
- R9: Port k's excitatory weight occupies bits [16k+15:16k] of `wex_in`/`wex_out`, and its inhibitory weight occupies the same bits of `win_in`/`win_out`. `chosen_port` is the binary port index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one update; operands sampled this cycle |
| reward | input | WIDTH | Reward value, Q8.8 |
| chosen_port | input | IDX_W | Port selected for the flow being rewarded |
| thr_in | input | WIDTH | Stored threshold before the update |
| wex_in | input | N_PORTS*WIDTH | Excitatory weights of the row, port k at slice k |
| win_in | input | N_PORTS*WIDTH | Inhibitory weights of the row, port k at slice k |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle pulse: results complete |
| thr_out | output | WIDTH | Updated threshold |
| wex_out | output | N_PORTS*WIDTH | Updated excitatory weights |
| win_out | output | N_PORTS*WIDTH | Updated inhibitory weights |

## Verification
The hardest situation to reach is a row whose total rate is zero after adjustment. In that case an unguarded rescale divides by zero and turns every weight into all-ones. The bench gets there by presenting an all-zero row with a reward exactly equal to the threshold, so the difference, the share and both sums are all zero. Saturation before rescaling is reached by giving the chosen port an excitatory weight just below full scale together with a reward far above the threshold. A second `start` is injected in the middle of a long divide to show that the operands latched first still govern the result.

// File: rtl/rlw_pkg.sv
package rlw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHARE_GO,
        ST_SHARE_WAIT,
        ST_ADJ,
        ST_NORM_GO,
        ST_NORM_WAIT,
        ST_FIN
    } rlw_state_e;

endpackage

// File: rtl/rlw_divider.sv
module rlw_divider #(
    parameter int NUM_W = 35,
    parameter int DEN_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             fin,
    output logic [NUM_W-1:0] quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic [NUM_W-1:0] q;
        logic [DEN_W-1:0] rem;
        logic [DEN_W-1:0] dv;
        logic [CNT_W-1:0] cnt;
        logic             act;
        logic             fin;
    } div_s;

    div_s cur_q, nxt_d;
    logic [DEN_W:0] trial, diff;
    logic           ge;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.fin = 1'b0;
        trial     = {cur_q.rem, cur_q.q[NUM_W-1]};
        diff      = trial - {1'b0, cur_q.dv};
        ge        = (trial >= {1'b0, cur_q.dv});
        if (go) begin
            nxt_d.q   = num;
            nxt_d.rem = '0;
            nxt_d.dv  = den;
            nxt_d.cnt = CNT_W'(NUM_W);
            nxt_d.act = 1'b1;
        end else if (cur_q.act) begin
            nxt_d.rem = ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
            nxt_d.q   = {cur_q.q[NUM_W-2:0], ge};
            nxt_d.cnt = cur_q.cnt - 1'b1;
            if (cur_q.cnt == CNT_W'(1)) begin
                nxt_d.act = 1'b0;
                nxt_d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign fin = cur_q.fin;
    assign quo = cur_q.q;
endmodule

// File: rtl/rlw_adjust.sv
module rlw_adjust #(
    parameter int N     = 4,
    parameter int W     = 16,
    parameter int IDX_W = $clog2(N),
    parameter int RW    = W + $clog2(2 * N)
) (
    input  logic [2*N-1:0][W-1:0] wt,
    input  logic [IDX_W-1:0]      chosen,
    input  logic                  rcase,
    input  logic [W-1:0]          delta,
    input  logic [W-1:0]          share,
    output logic [2*N-1:0][W-1:0] adj,
    output logic [RW-1:0]         r_old,
    output logic [RW-1:0]         r_new
);
    for (genvar p = 0; p < N; p++) begin : g_port
        logic          sel;
        logic [W-1:0]  ex_inc, in_inc;
        logic [W:0]    ex_sum, in_sum;
        assign sel    = (chosen == IDX_W'(p));
        assign ex_inc = rcase ? (sel ? delta : '0) : (sel ? '0 : share);
        assign in_inc = rcase ? (sel ? '0 : share) : (sel ? delta : '0);
        assign ex_sum = {1'b0, wt[p]} + {1'b0, ex_inc};
        assign in_sum = {1'b0, wt[N+p]} + {1'b0, in_inc};
        assign adj[p]   = ex_sum[W] ? '1 : ex_sum[W-1:0];
        assign adj[N+p] = in_sum[W] ? '1 : in_sum[W-1:0];
    end

    always_comb begin
        r_old = '0;
        r_new = '0;
        for (int i = 0; i < 2 * N; i++) begin
            r_old = r_old + RW'(wt[i]);
            r_new = r_new + RW'(adj[i]);
        end
    end
endmodule

// File: rtl/rlw_update_engine.sv
module rlw_update_engine
    import rlw_pkg::*;
#(
    parameter  int N_PORTS   = 4,
    parameter  int WIDTH     = 16,
    parameter  int AVG_SHIFT = 2,
    localparam int IDX_W     = $clog2(N_PORTS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [WIDTH-1:0]           reward,
    input  logic [IDX_W-1:0]           chosen_port,
    input  logic [WIDTH-1:0]           thr_in,
    input  logic [N_PORTS*WIDTH-1:0]   wex_in,
    input  logic [N_PORTS*WIDTH-1:0]   win_in,
    output logic                       busy,
    output logic                       done,
    output logic [WIDTH-1:0]           thr_out,
    output logic [N_PORTS*WIDTH-1:0]   wex_out,
    output logic [N_PORTS*WIDTH-1:0]   win_out
);
    localparam int NW     = 2 * N_PORTS;
    localparam int SLOT_W = $clog2(NW);
    localparam int RW     = WIDTH + SLOT_W;
    localparam int DNW    = WIDTH + RW;

    typedef logic [NW-1:0][WIDTH-1:0] wt_t;

    typedef struct packed {
        rlw_state_e        st;
        wt_t               wt;
        logic [WIDTH-1:0]  thr;
        logic [WIDTH-1:0]  delta;
        logic [WIDTH-1:0]  share;
        logic              rcase;
        logic [IDX_W-1:0]  chosen;
        logic [RW-1:0]     r_old;
        logic [RW-1:0]     r_new;
        logic [SLOT_W-1:0] slot;
    } eng_s;

    eng_s cur_q, nxt_d;

    wt_t            adj_wt, wt_now;
    logic [RW-1:0]  r_old_c, r_new_c;
    logic           div_go, div_fin;
    logic [DNW-1:0] div_num, div_quo;
    logic [RW-1:0]  div_den;
    logic [WIDTH-1:0] norm_w;

    assign wt_now = cur_q.wt;

    rlw_adjust #(.N(N_PORTS), .W(WIDTH), .IDX_W(IDX_W), .RW(RW)) u_adj (
        .wt    (cur_q.wt),
        .chosen(cur_q.chosen),
        .rcase (cur_q.rcase),
        .delta (cur_q.delta),
        .share (cur_q.share),
        .adj   (adj_wt),
        .r_old (r_old_c),
        .r_new (r_new_c)
    );

    rlw_divider #(.NUM_W(DNW), .DEN_W(RW)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (div_go),
        .num  (div_num),
        .den  (div_den),
        .fin  (div_fin),
        .quo  (div_quo)
    );

    always_comb begin
        if (cur_q.st == ST_SHARE_GO) begin
            div_num = DNW'(cur_q.delta);
            div_den = RW'(N_PORTS - 1);
        end else begin
            div_num = DNW'(cur_q.wt[cur_q.slot]) * DNW'(cur_q.r_old);
            div_den = cur_q.r_new;
        end
        norm_w = (|div_quo[DNW-1:WIDTH]) ? '1 : div_quo[WIDTH-1:0];
    end

    always_comb begin
        nxt_d  = cur_q;
        div_go = 1'b0;
        case (cur_q.st)
            ST_IDLE: if (start) begin
                for (int p = 0; p < N_PORTS; p++) begin
                    nxt_d.wt[p]         = wex_in[p*WIDTH +: WIDTH];
                    nxt_d.wt[N_PORTS+p] = win_in[p*WIDTH +: WIDTH];
                end
                nxt_d.thr    = thr_in - (thr_in >> AVG_SHIFT) + (reward >> AVG_SHIFT);
                nxt_d.rcase  = (reward >= thr_in);
                nxt_d.delta  = (reward >= thr_in) ? reward - thr_in : thr_in - reward;
                nxt_d.chosen = chosen_port;
                nxt_d.st     = ST_SHARE_GO;
            end
            ST_SHARE_GO: begin
                div_go   = 1'b1;
                nxt_d.st = ST_SHARE_WAIT;
            end
            ST_SHARE_WAIT: if (div_fin) begin
                nxt_d.share = div_quo[WIDTH-1:0];
                nxt_d.st    = ST_ADJ;
            end
            ST_ADJ: begin
                nxt_d.wt    = adj_wt;
                nxt_d.r_old = r_old_c;
                nxt_d.r_new = r_new_c;
                nxt_d.slot  = '0;
                nxt_d.st    = (r_new_c == '0) ? ST_FIN : ST_NORM_GO;
            end
            ST_NORM_GO: begin
                div_go   = 1'b1;
                nxt_d.st = ST_NORM_WAIT;
            end
            ST_NORM_WAIT: if (div_fin) begin
                nxt_d.wt[cur_q.slot] = norm_w;
                if (cur_q.slot == SLOT_W'(NW - 1)) nxt_d.st = ST_FIN;
                else begin
                    nxt_d.slot = cur_q.slot + 1'b1;
                    nxt_d.st   = ST_NORM_GO;
                end
            end
            ST_FIN:  nxt_d.st = ST_IDLE;
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= '0;
            cur_q.st <= ST_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    for (genvar p = 0; p < N_PORTS; p++) begin : g_out
        assign wex_out[p*WIDTH +: WIDTH] = cur_q.wt[p];
        assign win_out[p*WIDTH +: WIDTH] = cur_q.wt[N_PORTS+p];
    end

    assign thr_out = cur_q.thr;
    assign busy    = (cur_q.st != ST_IDLE);
    assign done    = (cur_q.st == ST_FIN);
endmodule

// File: rtl/rlw_checker.sv
module rlw_checker #(
    parameter int N = 4,
    parameter int W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  busy,
    input logic                  done,
    input logic [W-1:0]          thr_out,
    input logic [N*W-1:0]        wex_out,
    input logic [N*W-1:0]        win_out,
    input logic [2*N-1:0][W-1:0] wt_now,
    input logic [2*N-1:0][W-1:0] adj_wt
);
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(thr_out) && $stable(wex_out) && $stable(win_out)));

    a_r7_busy_ends_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    for (genvar i = 0; i < 2 * N; i++) begin : g_mono
        a_r5_adjust_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
            adj_wt[i] >= wt_now[i]);
    end
endmodule

bind rlw_update_engine rlw_checker #(.N(N_PORTS), .W(WIDTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .thr_out(thr_out),
    .wex_out(wex_out),
    .win_out(win_out),
    .wt_now (wt_now),
    .adj_wt (adj_wt)
);

// File: tb/rlw_update_engine_tb.sv
`timescale 1ns/1ps
module rlw_update_engine_tb;
    localparam int N = 4;
    localparam int W = 16;
    localparam int S = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [W-1:0]   reward = '0;
    logic [1:0]     chosen_port = '0;
    logic [W-1:0]   thr_in = '0;
    logic [N*W-1:0] wex_in = '0;
    logic [N*W-1:0] win_in = '0;
    logic           busy, done;
    logic [W-1:0]   thr_out;
    logic [N*W-1:0] wex_out, win_out;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    rlw_update_engine #(.N_PORTS(N), .WIDTH(W), .AVG_SHIFT(S)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .reward(reward),
        .chosen_port(chosen_port), .thr_in(thr_in), .wex_in(wex_in),
        .win_in(win_in), .busy(busy), .done(done), .thr_out(thr_out),
        .wex_out(wex_out), .win_out(win_out)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL R7 watchdog expired: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Independent model of one update, built from R2..R6 and R9.
    task automatic model(input logic [W-1:0] r, input logic [W-1:0] t, input int j,
                         input logic [N*W-1:0] wex, input logic [N*W-1:0] win,
                         output logic [W-1:0] t_e, output logic [N*W-1:0] wex_e,
                         output logic [N*W-1:0] win_e);
        longint w[2*N];
        longint a[2*N];
        longint d, sh, ro, rn;
        bit rc;
        t_e = W'(longint'(t) - longint'(t >> S) + longint'(r >> S));
        rc = (r >= t);
        d  = rc ? longint'(r) - longint'(t) : longint'(t) - longint'(r);
        sh = d / (N - 1);
        ro = 0; rn = 0;
        for (int k = 0; k < N; k++) begin
            w[k]   = longint'(wex[k*W +: W]);
            w[N+k] = longint'(win[k*W +: W]);
        end
        for (int k = 0; k < N; k++) begin
            a[k]   = w[k]   + (rc ? ((k == j) ? d : 0) : ((k == j) ? 0 : sh));
            a[N+k] = w[N+k] + (rc ? ((k == j) ? 0 : sh) : ((k == j) ? d : 0));
        end
        for (int k = 0; k < 2 * N; k++) begin
            if (a[k] > 65535) a[k] = 65535;
            ro += w[k];
            rn += a[k];
        end
        for (int k = 0; k < 2 * N; k++)
            if (rn != 0) a[k] = (a[k] * ro) / rn;
        for (int k = 0; k < N; k++) begin
            wex_e[k*W +: W] = W'(a[k]);
            win_e[k*W +: W] = W'(a[N+k]);
        end
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; break; end
        end
    endtask

    task automatic run_case(input string req, input logic [W-1:0] r, input logic [W-1:0] t,
                            input int j, input logic [N*W-1:0] wex,
                            input logic [N*W-1:0] win, input bit poke);
        logic [W-1:0]   t_e;
        logic [N*W-1:0] wex_e, win_e;
        bit ok;
        model(r, t, j, wex, win, t_e, wex_e, win_e);
        @(negedge clk);
        reward = r; thr_in = t; chosen_port = 2'(j); wex_in = wex; win_in = win;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R7", "busy after start", longint'(busy), 1);
        if (poke) begin
            repeat (10) @(negedge clk);
            // R8: second start with different operands while busy
            reward = ~r; thr_in = ~t; chosen_port = 2'(j + 1);
            wex_in = ~wex; win_in = ~win;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(ok);
        chk("R7", "done reached", longint'(ok), 1);
        chk("R2", "threshold", longint'(thr_out), longint'(t_e));
        for (int k = 0; k < N; k++) begin
            chk(req, $sformatf("wex port %0d", k), longint'(wex_out[k*W +: W]), longint'(wex_e[k*W +: W]));
            chk(req, $sformatf("win port %0d", k), longint'(win_out[k*W +: W]), longint'(win_e[k*W +: W]));
        end
        @(negedge clk);
        chk("R7", "done single pulse", longint'(done), 0);
        chk("R7", "busy cleared", longint'(busy), 0);
    endtask

    task automatic test_reset();
        chk("R1", "busy", longint'(busy), 0);
        chk("R1", "done", longint'(done), 0);
        chk("R1", "thr_out", longint'(thr_out), 0);
        chk("R1", "wex_out", longint'(wex_out != '0), 0);
        chk("R1", "win_out", longint'(win_out != '0), 0);
    endtask

    task automatic test_hold();
        logic [W-1:0]   t0;
        logic [N*W-1:0] e0, i0;
        t0 = thr_out; e0 = wex_out; i0 = win_out;
        reward = 16'h1234; thr_in = 16'h4321; wex_in = '1; win_in = '1;
        repeat (5) @(negedge clk);
        chk("R7", "idle hold thr", longint'(thr_out), longint'(t0));
        chk("R7", "idle hold wex", longint'(wex_out == e0), 1);
        chk("R7", "idle hold win", longint'(win_out == i0), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        // R3 + R6 + R9: reward case, chosen port 1
        run_case("R3", 16'h0300, 16'h0100, 1,
                 {16'h0100, 16'h0080, 16'h0200, 16'h0040},
                 {16'h0020, 16'h0060, 16'h0010, 16'h0090}, 1'b0);
        // R4 + R6: punish case, chosen port 0
        run_case("R4", 16'h0080, 16'h0400, 0,
                 {16'h0150, 16'h0033, 16'h0210, 16'h0400},
                 {16'h0011, 16'h0222, 16'h0090, 16'h0005}, 1'b0);
        // R3: reward equal to threshold counts as reward with zero delta
        run_case("R3", 16'h0200, 16'h0200, 2,
                 {16'h0301, 16'h0007, 16'h00ff, 16'h1000},
                 {16'h0002, 16'h0777, 16'h0100, 16'h0003}, 1'b0);
        // R5 + R9: saturation on highest port index
        run_case("R5", 16'hF000, 16'h0010, 3,
                 {16'hFFF0, 16'h0100, 16'h0100, 16'h0100},
                 {16'hFF00, 16'h0010, 16'h0020, 16'h0030}, 1'b0);
        // R6: all-zero row, zero rate after adjustment
        run_case("R6", 16'h0155, 16'h0155, 0, '0, '0, 1'b0);
        // R8: start while busy ignored
        run_case("R8", 16'h0500, 16'h0180, 2,
                 {16'h0040, 16'h0120, 16'h0080, 16'h0300},
                 {16'h0070, 16'h0010, 16'h0200, 16'h0050}, 1'b1);
        test_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule